// File: doc/BRIEF.md
# Rotated Tiled-View Address Generator

This block converts a pixel coordinate inside a two-dimensional tiled container into a 32-bit view address. The caller supplies a pixel format, a three-bit orientation code and the X and Y coordinates. The block returns the address, a flag that marks an out-of-range coordinate, and the line stride that goes with the chosen format and orientation.

Each format leaves a different number of low coordinate bits unused. The block narrows the X and Y fields to match, checks the coordinate against those widths, and applies mirroring and the X/Y swap. It then packs the linear offset beneath the format and orientation codes. The result is registered for one cycle and qualified by a valid strobe. Slot allocation, translation-table contents and the memory access itself belong to other blocks.

Top module: `tiled_view_addr`

## Requirements
- R1: Address bits [28:27] hold the format code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = page mode.
- R2: Address bits [31:29] hold the orientation code unchanged. Bit 0 is X-invert, bit 1 is Y-invert and bit 2 is the X/Y swap.
- R3: With default parameters (container width 14 bits, height 13 bits, slot 6x6 bits) the legal X/Y widths are 14/13 for 8-bit, 14/12 for 16-bit, 13/12 for 32-bit and 8/7 for page mode.
- R4: When X or Y exceeds its all-ones mask, the address is 0 and `coord_invalid` is 1.
- R5: Orientation bit 0 replaces X with X XOR its mask before the offset is formed.
- R6: Orientation bit 1 replaces Y with Y XOR its mask before the offset is formed.
- R7: With bit 2 set the offset is (X << ybits) + Y; otherwise it is (Y << xbits) + X.
- R8: The offset is shifted left by the sum of the format's unused X and Y bits, which are 0, 1, 2 and 12 for formats 0..3. The shifted offset fills address bits [26:0].
- R9: With bit 2 set the stride is 1 << (13 + unused X bits); otherwise it is 1 << (14 + unused Y bits). Unused X bits are 0/0/1/6 and unused Y bits are 0/1/1/6 for formats 0..3.
- R10: `valid_out` equals `valid_in` one clock later. Address, flag and stride update only on a cycle where `valid_in` is high and hold otherwise.
- R11: During reset, `valid_out`, `addr`, `coord_invalid` and `stride` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Request strobe |
| fmt | input | 2 | Pixel format code |
| orient | input | 3 | Orientation code |
| x | input | 16 | Pixel X coordinate |
| y | input | 16 | Pixel Y coordinate |
| valid_out | output | 1 | Result strobe, one cycle after the request |
| addr | output | 32 | View address |
| coord_invalid | output | 1 | Coordinate outside the format's range |
| stride | output | 21 | Line stride in bytes |

## Verification
The main path is tried with all four formats under every orientation code, at the zero corner, at the mask corner, and at asymmetric coordinates. The asymmetric values show whether a swap was confused with a mirror, and whether X and Y were exchanged. Coordinates one above each format's mask tell a correct per-format width apart from a shared one. Since only a single axis is out of range each time, a check that covers just one axis would be caught. Idle cycles with changed inputs separate a register that loads on the strobe from one that loads on every cycle.

// File: rtl/tvag_pkg.sv
package tvag_pkg;

  typedef enum logic [1:0] {
    FMT_B8   = 2'd0,
    FMT_B16  = 2'd1,
    FMT_B32  = 2'd2,
    FMT_PAGE = 2'd3
  } pix_fmt_e;

  localparam int ORI_XINV = 0;
  localparam int ORI_YINV = 1;
  localparam int ORI_SWAP = 2;

  // Low X bits that a format leaves unused (part of its bytes per pixel).
  function automatic int unsigned unused_x(pix_fmt_e f, int unsigned slot_w_bits);
    case (f)
      FMT_B32:  return 1;
      FMT_PAGE: return slot_w_bits;
      default:  return 0;
    endcase
  endfunction

  // Low Y bits that a format leaves unused.
  function automatic int unsigned unused_y(pix_fmt_e f, int unsigned slot_h_bits);
    case (f)
      FMT_B8:   return 0;
      FMT_PAGE: return slot_h_bits;
      default:  return 1;
    endcase
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tvag_range_check.sv
module tvag_range_check
  import tvag_pkg::*;
#(
  parameter int W_BITS  = 14,
  parameter int H_BITS  = 13,
  parameter int SW_BITS = 6,
  parameter int SH_BITS = 6,
  parameter int COORD_W = 16,
  localparam int BITS_W = $clog2(COORD_W + 1)
) (
  input  pix_fmt_e             fmt,
  input  logic [COORD_W-1:0]   x_in,
  input  logic [COORD_W-1:0]   y_in,
  output logic [COORD_W-1:0]   x_mask,
  output logic [COORD_W-1:0]   y_mask,
  output logic [BITS_W-1:0]    x_bits,
  output logic [BITS_W-1:0]    y_bits,
  output logic [BITS_W-1:0]    align_sh,
  output logic                 out_of_range
);

  localparam logic [COORD_W-1:0] ONES = '1;

  int unsigned xs, ys, xb, yb;

  always_comb begin
    xs = unused_x(fmt, SW_BITS);
    ys = unused_y(fmt, SH_BITS);
    xb = W_BITS - xs;
    yb = H_BITS - ys;
  end

  assign x_bits   = BITS_W'(xb);
  assign y_bits   = BITS_W'(yb);
  assign align_sh = BITS_W'(xs + ys);
  assign x_mask   = ONES >> (COORD_W - xb);
  assign y_mask   = ONES >> (COORD_W - yb);

  assign out_of_range = (x_in > x_mask) || (y_in > y_mask);

endmodule

// File: rtl/tvag_orient.sv
module tvag_orient #(
  parameter int COORD_W = 16,
  parameter int OFF_W   = 27,
  localparam int BITS_W = $clog2(COORD_W + 1)
) (
  input  logic [COORD_W-1:0] x_in,
  input  logic [COORD_W-1:0] y_in,
  input  logic [COORD_W-1:0] x_mask,
  input  logic [COORD_W-1:0] y_mask,
  input  logic [BITS_W-1:0]  x_bits,
  input  logic [BITS_W-1:0]  y_bits,
  input  logic [BITS_W-1:0]  align_sh,
  input  logic [2:0]         orient,
  output logic [OFF_W-1:0]   offset
);

  import tvag_pkg::*;

  logic [COORD_W-1:0] x_m, y_m;
  logic [OFF_W-1:0]   x_e, y_e, lin;

  // Each orientation bit acts independently.
  assign x_m = orient[ORI_XINV] ? (x_in ^ x_mask) : x_in;
  assign y_m = orient[ORI_YINV] ? (y_in ^ y_mask) : y_in;

  assign x_e = OFF_W'(x_m);
  assign y_e = OFF_W'(y_m);

  assign lin    = orient[ORI_SWAP] ? ((x_e << y_bits) + y_e)
                                   : ((y_e << x_bits) + x_e);
  assign offset = lin << align_sh;

endmodule

// File: rtl/tvag_stride.sv
module tvag_stride
  import tvag_pkg::*;
#(
  parameter int W_BITS   = 14,
  parameter int H_BITS   = 13,
  parameter int SW_BITS  = 6,
  parameter int SH_BITS  = 6,
  parameter int STRIDE_W = 21
) (
  input  pix_fmt_e              fmt,
  input  logic                  swap,
  output logic [STRIDE_W-1:0]   stride
);

  int unsigned sh;

  always_comb begin
    if (swap) sh = H_BITS + unused_x(fmt, SW_BITS);
    else      sh = W_BITS + unused_y(fmt, SH_BITS);
  end

  assign stride = STRIDE_W'(1) << sh;

endmodule

// File: rtl/tiled_view_addr.sv
module tiled_view_addr
  import tvag_pkg::*;
#(
  parameter int W_BITS  = 14,
  parameter int H_BITS  = 13,
  parameter int SW_BITS = 6,
  parameter int SH_BITS = 6,
  parameter int COORD_W = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int OFF_W    = W_BITS + H_BITS,
  localparam int ADDR_W   = OFF_W + 5,
  localparam int STRIDE_W = max2(W_BITS + SH_BITS, H_BITS + SW_BITS) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid_in,
  input  logic [1:0]           fmt,
  input  logic [2:0]           orient,
  input  logic [COORD_W-1:0]   x,
  input  logic [COORD_W-1:0]   y,
  output logic                 valid_out,
  output logic [ADDR_W-1:0]    addr,
  output logic                 coord_invalid,
  output logic [STRIDE_W-1:0]  stride
);

  localparam int BITS_W = $clog2(COORD_W + 1);

  pix_fmt_e             fmt_e;
  logic [COORD_W-1:0]   x_mask, y_mask;
  logic [BITS_W-1:0]    x_bits, y_bits, align_sh;
  logic                 range_bad;
  logic [OFF_W-1:0]     view_off;
  logic [ADDR_W-1:0]    addr_c;
  logic [STRIDE_W-1:0]  stride_c;

  assign fmt_e = pix_fmt_e'(fmt);

  tvag_range_check #(
    .W_BITS(W_BITS), .H_BITS(H_BITS), .SW_BITS(SW_BITS),
    .SH_BITS(SH_BITS), .COORD_W(COORD_W)
  ) u_range (
    .fmt(fmt_e), .x_in(x), .y_in(y),
    .x_mask(x_mask), .y_mask(y_mask),
    .x_bits(x_bits), .y_bits(y_bits), .align_sh(align_sh),
    .out_of_range(range_bad)
  );

  tvag_orient #(.COORD_W(COORD_W), .OFF_W(OFF_W)) u_orient (
    .x_in(x), .y_in(y), .x_mask(x_mask), .y_mask(y_mask),
    .x_bits(x_bits), .y_bits(y_bits), .align_sh(align_sh),
    .orient(orient), .offset(view_off)
  );

  tvag_stride #(
    .W_BITS(W_BITS), .H_BITS(H_BITS), .SW_BITS(SW_BITS),
    .SH_BITS(SH_BITS), .STRIDE_W(STRIDE_W)
  ) u_stride (
    .fmt(fmt_e), .swap(orient[ORI_SWAP]), .stride(stride_c)
  );

  // Orientation on top, format below it, shifted offset underneath.
  assign addr_c = range_bad ? '0 : {orient, fmt, view_off};

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          valid_out     <= 1'b0;
          addr          <= '0;
          coord_invalid <= 1'b0;
          stride        <= '0;
        end else begin
          valid_out <= valid_in;
          if (valid_in) begin
            addr          <= addr_c;
            coord_invalid <= range_bad;
            stride        <= stride_c;
          end
        end
      end
    end else begin : g_comb
      assign valid_out     = valid_in;
      assign addr          = addr_c;
      assign coord_invalid = range_bad;
      assign stride        = stride_c;
    end
  endgenerate

endmodule

// File: rtl/tiled_view_addr_chk.sv
module tiled_view_addr_chk #(
  parameter int OFF_W    = 27,
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 21,
  parameter bit REG_OUT  = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                valid_in,
  input logic [1:0]          fmt,
  input logic [2:0]          orient,
  input logic                valid_out,
  input logic [ADDR_W-1:0]   addr,
  input logic                coord_invalid,
  input logic [STRIDE_W-1:0] stride
);

  generate
    if (REG_OUT) begin : g_props
      a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);

      a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);

      a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> ($stable(addr) && $stable(stride) && $stable(coord_invalid)));

      a_r4_zero_on_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && coord_invalid) |-> (addr == '0));

      a_r9_stride_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> ($countones(stride) == 1));

      a_r1_fmt_field: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> (coord_invalid || (addr[OFF_W+1:OFF_W] == $past(fmt))));

      a_r2_orient_field: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> (coord_invalid || (addr[ADDR_W-1:OFF_W+2] == $past(orient))));
    end
  endgenerate

endmodule

bind tiled_view_addr tiled_view_addr_chk #(
  .OFF_W(OFF_W), .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .fmt(fmt), .orient(orient),
  .valid_out(valid_out), .addr(addr), .coord_invalid(coord_invalid),
  .stride(stride)
);

// File: tb/test_tiled_view_addr.sv
`timescale 1ns/1ps
module test_tiled_view_addr;

  localparam int CW = 16;
  localparam int AW = 32;
  localparam int SW = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_in = 1'b0;
  logic [1:0]    fmt = '0;
  logic [2:0]    orient = '0;
  logic [CW-1:0] x = '0, y = '0;
  logic          valid_out, coord_invalid;
  logic [AW-1:0] addr;
  logic [SW-1:0] stride;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tiled_view_addr i_tiled_view_addr (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .fmt(fmt), .orient(orient),
    .x(x), .y(y), .valid_out(valid_out), .addr(addr),
    .coord_invalid(coord_invalid), .stride(stride)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Independent model written with arithmetic instead of bit masking.
  task automatic model(input logic [1:0] f, input logic [2:0] o,
                       input logic [CW-1:0] xi, input logic [CW-1:0] yi,
                       output logic [AW-1:0] a, output logic inv,
                       output logic [SW-1:0] s);
    int xb, yb, xs, ys;
    longint unsigned mx, my, xv, yv, off;
    case (f)
      2'd0: begin xs = 0; ys = 0; end
      2'd1: begin xs = 0; ys = 1; end
      2'd2: begin xs = 1; ys = 1; end
      default: begin xs = 6; ys = 6; end
    endcase
    xb = 14 - xs;
    yb = 13 - ys;
    mx = (64'd1 << xb) - 1;
    my = (64'd1 << yb) - 1;
    xv = longint'(xi);
    yv = longint'(yi);
    s = o[2] ? SW'(64'd1 << (13 + xs)) : SW'(64'd1 << (14 + ys));
    if (xv > mx || yv > my) begin
      a = '0;
      inv = 1'b1;
    end else begin
      if (o[0]) xv = mx - xv;
      if (o[1]) yv = my - yv;
      off = o[2] ? (xv * (64'd1 << yb) + yv) : (yv * (64'd1 << xb) + xv);
      off = off * (64'd1 << (xs + ys));
      a = AW'(longint'(o) * 64'd536870912 + longint'(f) * 64'd134217728 + off);
      inv = 1'b0;
    end
  endtask

  task automatic apply(input logic [1:0] f, input logic [2:0] o,
                       input logic [CW-1:0] xi, input logic [CW-1:0] yi);
    @(negedge clk);
    fmt = f; orient = o; x = xi; y = yi; valid_in = 1'b1;
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [AW-1:0] a,
                            input logic inv, input logic [SW-1:0] s);
    chk({req, " valid"}, 64'(valid_out), 64'd1);
    chk({req, " addr"}, 64'(addr), 64'(a));
    chk({req, " invalid"}, 64'(coord_invalid), 64'(inv));
    chk({req, " stride"}, 64'(stride), 64'(s));
  endtask

  // {fmt, orient, x, y}
  localparam int NV = 16;
  localparam logic [36:0] STIM [NV] = '{
    {2'd0, 3'd0, 16'h0000, 16'h0000},
    {2'd0, 3'd4, 16'h0123, 16'h0045},
    {2'd0, 3'd3, 16'h3FFF, 16'h1FFF},
    {2'd1, 3'd0, 16'h0007, 16'h0002},
    {2'd1, 3'd4, 16'h0007, 16'h0002},
    {2'd1, 3'd2, 16'h1234, 16'h0ABC},
    {2'd1, 3'd6, 16'h3FFF, 16'h0FFF},
    {2'd2, 3'd1, 16'h0011, 16'h0022},
    {2'd2, 3'd5, 16'h0100, 16'h0003},
    {2'd2, 3'd7, 16'h1FFF, 16'h0FFF},
    {2'd3, 3'd0, 16'h00FF, 16'h007F},
    {2'd3, 3'd4, 16'h0012, 16'h0034},
    {2'd3, 3'd5, 16'h0001, 16'h0002},
    {2'd3, 3'd2, 16'h0080, 16'h0000},
    {2'd2, 3'd0, 16'h0000, 16'h1000},
    {2'd0, 3'd6, 16'h4000, 16'h0000}
  };

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] ea;
    logic          ei;
    logic [SW-1:0] es;
    logic [AW-1:0] held_a;

    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11 valid_out", 64'(valid_out), 64'd0);
    chk("R11 addr", 64'(addr), 64'd0);
    chk("R11 coord_invalid", 64'(coord_invalid), 64'd0);
    chk("R11 stride", 64'(stride), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1 R2 R5 R6 R7 R8 R9 against the model
    for (int i = 0; i < NV; i++) begin
      apply(STIM[i][36:35], STIM[i][34:32], STIM[i][31:16], STIM[i][15:0]);
      model(STIM[i][36:35], STIM[i][34:32], STIM[i][31:16], STIM[i][15:0], ea, ei, es);
      expect_out($sformatf("R7 R8 table[%0d]", i), ea, ei, es);
    end

    // R8 R1: 32-bit at X mask corner
    apply(2'd2, 3'd0, 16'h1FFF, 16'h0000);
    expect_out("R8", 32'h10007FFC, 1'b0, 21'h08000);
    chk("R1 fmt field", 64'(addr[28:27]), 64'd2);
    // R3 R4: one above 32-bit X width
    apply(2'd2, 3'd0, 16'h2000, 16'h0000);
    expect_out("R3 R4 x32", 32'h0, 1'b1, 21'h08000);
    // R3 R4: 16-bit Y one above mask
    apply(2'd1, 3'd0, 16'h0000, 16'h1000);
    expect_out("R3 R4 y16", 32'h0, 1'b1, 21'h08000);
    // R3: page mode X 255 legal, Y 128 illegal
    apply(2'd3, 3'd0, 16'h00FF, 16'h0000);
    expect_out("R3 page x", 32'h180FF000, 1'b0, 21'h100000);
    apply(2'd3, 3'd0, 16'h0000, 16'h0080);
    expect_out("R3 page y", 32'h0, 1'b1, 21'h100000);
    // R3: 8-bit full width legal
    apply(2'd0, 3'd0, 16'h3FFF, 16'h1FFF);
    expect_out("R3 b8 max", 32'h07FFFFFF, 1'b0, 21'h04000);
    // Basic 8-bit
    apply(2'd0, 3'd0, 16'h0003, 16'h0002);
    expect_out("R7 plain", 32'h00008003, 1'b0, 21'h04000);
    // R5: X invert, 16-bit
    apply(2'd1, 3'd1, 16'h0000, 16'h0005);
    expect_out("R5", 32'h2802FFFE, 1'b0, 21'h08000);
    // R6: Y invert, 8-bit
    apply(2'd0, 3'd2, 16'h0001, 16'h0000);
    expect_out("R6", 32'h47FFC001, 1'b0, 21'h04000);
    // R2 R7 R9: page, swap with both inverts
    apply(2'd3, 3'd7, 16'h0000, 16'h0000);
    expect_out("R2 R7 R9", 32'hFFFFF000, 1'b0, 21'h80000);
    chk("R2 orient field", 64'(addr[31:29]), 64'd7);

    // R10: hold while idle, even with new inputs
    held_a = addr;
    @(negedge clk);
    valid_in = 1'b0; fmt = 2'd1; orient = 3'd4; x = 16'h0011; y = 16'h0022;
    @(negedge clk);
    chk("R10 idle valid_out", 64'(valid_out), 64'd0);
    chk("R10 hold addr", 64'(addr), 64'(held_a));
    chk("R10 hold stride", 64'(stride), 64'h80000);
    // R10: latency of one clock
    valid_in = 1'b1;
    #1;
    chk("R10 not yet", 64'(valid_out), 64'd0);
    @(negedge clk);
    model(2'd1, 3'd4, 16'h0011, 16'h0022, ea, ei, es);
    expect_out("R10 one cycle", ea, ei, es);
    valid_in = 1'b0;
    @(negedge clk);
    chk("R10 drop", 64'(valid_out), 64'd0);

    // R11: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 rerst addr", 64'(addr), 64'd0);
    chk("R11 rerst stride", 64'(stride), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule